// File: doc/BRIEF.md
# LED and Stop Output Controller

This block drives the indicator and level outputs of a voice playback controller. Two small registers configure it. The stop register sets three static output levels, called A, B and C. The mode register decides four things: whether the LEDs flash or stay lit, whether the shared fourth pin is a trigger input or an output, which output that pin carries, and whether the trigger debouncer uses the long or the short window.

LED activity follows playback. The sequencer reports that a sound is playing and whether the current sound section asks for the LEDs. Straps fixed at integration time set three things: whether the two LEDs flash in phase or alternately, whether LED1 obeys the section flag, and whether LED2 obeys the section flag or simply shows the C level.

The flash waveform is a 50% square wave from a clock divider. Its half-period is CLK_HZ/(2*FLASH_HZ) cycles, which gives 3 Hz by default. The divider restarts whenever playback starts, so every sound begins with the LEDs lit. Every output comes from registered state, so a register write or a change of a playback input shows at the ports one clock edge later.

Top module: `led_stop_ctrl`

## Requirements
- R1: After reset, stpa and stpb are 1, the stored C level is 1, pin4_oe is 0, pin4_out is 0, deb_long is 1 and led1 is 0.
- R2: A write with reg_sel=0 stores reg_wdata[0] as the A level (stpa), reg_wdata[1] as the B level (stpb) and reg_wdata[2] as the C level, visible after that clock edge; reg_wdata[7:3] have no effect.
- R3: A write with reg_sel=1 stores reg_wdata[7:4] as the mode: bit 7 flash (1) or steady (0), bit 6 pin carries LED2 (1) or the C level (0), bit 5 pin is a trigger input (1) or an output (0), bit 4 long debounce (1) or short (0), with deb_long = bit 4; reg_wdata[3:0] have no effect, and without a write the mode holds.
- R4: When mode bit 5 is 1, pin4_oe and pin4_out are 0. When it is 0, pin4_oe is 1 and pin4_out equals LED2 if mode bit 6 is 1 and the C level otherwise.
- R5: In flash mode, a section-controlled LED that stays enabled is on for HALF cycles, then off for HALF cycles, and repeats, where HALF = CLK_HZ/(2*FLASH_HZ).
- R6: In steady mode, an enabled LED stays on for as long as it is enabled.
- R7: A section-controlled LED is enabled only when playing and sect_led_on were both 1 at the previous clock edge.
- R8: With opt_alternate=1 in flash mode, a section-controlled LED2 is on exactly in the half-periods where LED1 is off. With opt_alternate=0, the two LEDs flash in phase.
- R9: With opt_led1_sect=0, LED1 is enabled whenever playing was 1 at the previous edge, whatever sect_led_on is.
- R10: With opt_led2_sect=0, LED2 equals the stored C level.
- R11: The first clock edge that sees playing at 1 after it was 0 restarts the flash wave in its on half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the stop register, 1 selects the mode register |
| reg_wdata | input | 8 | Write data |
| playing | input | 1 | A sound is being played |
| sect_led_on | input | 1 | The current section requests the LEDs |
| opt_alternate | input | 1 | Strap: 1 makes the LEDs alternate, 0 keeps them in phase |
| opt_led1_sect | input | 1 | Strap: 1 makes LED1 follow the section flag |
| opt_led2_sect | input | 1 | Strap: 1 makes LED2 follow the section flag, 0 makes it show the C level |
| led1 | output | 1 | LED1 drive |
| pin4_out | output | 1 | Shared pin output value |
| pin4_oe | output | 1 | Shared pin output enable |
| stpa | output | 1 | Stop level A |
| stpb | output | 1 | Stop level B |
| deb_long | output | 1 | Debounce window select for the trigger block |

## Verification
A mode register write can land on the same clock edge on which playback starts. That edge then changes both the flash/steady choice and the phase of the flash wave. The bench provokes this with a directed write of a new mode in the cycle where playing first rises, and again at random during a long randomized run. It judges the result against a model in which both updates take effect on that edge: the wave starts in its on half under the newly written mode.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   typedef struct packed {
      logic flash;     // 1 flash, 0 steady
      logic pin_led2;  // 1 pin carries LED2, 0 the C level
      logic pin_trig;  // 1 pin is a trigger input
      logic deb_long;  // 1 long debounce window
   } lsc_mode_t;

   localparam lsc_mode_t MODE_RST = '{flash: 1'b1, pin_led2: 1'b1, pin_trig: 1'b1, deb_long: 1'b1};
   localparam int        STOP_W   = 3;
   localparam logic [STOP_W-1:0] STOP_RST = '1;

   typedef enum logic { SEL_STOP = 1'b0, SEL_MODE = 1'b1 } lsc_sel_e;
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
   import lsc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  lsc_sel_e              sel,
   input  logic [DATA_W-1:0]     wdata,
   output logic [STOP_W-1:0]     stop_lvl,
   output lsc_mode_t             mode
);
   localparam int MODE_LSB = DATA_W - 4;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("lsc_regs: DATA_W must be at least 8");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{wdata[MODE_LSB-1:STOP_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_lvl <= STOP_RST;
         mode     <= MODE_RST;
      end else if (wr) begin
         if (sel == SEL_MODE) mode     <= lsc_mode_t'(wdata[DATA_W-1:MODE_LSB]);
         else                 stop_lvl <= wdata[STOP_W-1:0];
      end
   end

   // R3
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel == SEL_MODE) |=> $stable(mode));
   // R2
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel == SEL_STOP) |=> $stable(stop_lvl));
endmodule

// File: rtl/lsc_flash_div.sv
module lsc_flash_div #(
   parameter int HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic phase     // 0 on half, 1 off half
);
   generate
      if (HALF < 1) begin : g_bad_half
         $error("lsc_flash_div: HALF must be at least 1");
      end

      if (HALF == 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase <= 1'b0;
            else if (restart) phase <= 1'b0;
            else              phase <= ~phase;
         end
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               phase <= 1'b0;
            end else if (restart) begin
               cnt   <= '0;
               phase <= 1'b0;
            end else if (cnt == CW'(HALF - 1)) begin
               cnt   <= '0;
               phase <= ~phase;
            end else begin
               cnt   <= cnt + 1'b1;
            end
         end

         // R5
         half_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && cnt == CW'(HALF - 1)) |=> (phase != $past(phase)));
      end
   endgenerate

   // R11
   restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !phase);
endmodule

// File: rtl/lsc_led_drive.sv
module lsc_led_drive (
   input  logic play_q,
   input  logic sect_q,
   input  logic phase,
   input  logic flash,
   input  logic lvl_c,
   input  logic opt_alternate,
   input  logic opt_led1_sect,
   input  logic opt_led2_sect,
   output logic led1,
   output logic led2
);
   logic active, wave1, wave2, en1;

   always_comb begin
      active = play_q & sect_q;
      wave1  = flash ? ~phase : 1'b1;
      wave2  = flash ? (opt_alternate ? phase : ~phase) : 1'b1;
      en1    = opt_led1_sect ? active : play_q;
      led1   = en1 & wave1;
      led2   = opt_led2_sect ? (active & wave2) : lvl_c;
   end
endmodule

// File: rtl/lsc_pin_mux.sv
module lsc_pin_mux
   import lsc_pkg::*;
(
   input  lsc_mode_t mode,
   input  logic      led2,
   input  logic      lvl_c,
   output logic      pin_out,
   output logic      pin_oe
);
   always_comb begin
      if (mode.pin_trig) begin
         pin_oe  = 1'b0;
         pin_out = 1'b0;
      end else begin
         pin_oe  = 1'b1;
         pin_out = mode.pin_led2 ? led2 : lvl_c;
      end
   end
endmodule

// File: rtl/led_stop_ctrl.sv
module led_stop_ctrl
   import lsc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int CLK_HZ   = 3_000_000,
   parameter int FLASH_HZ = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              playing,
   input  logic              sect_led_on,
   input  logic              opt_alternate,
   input  logic              opt_led1_sect,
   input  logic              opt_led2_sect,
   output logic              led1,
   output logic              pin4_out,
   output logic              pin4_oe,
   output logic              stpa,
   output logic              stpb,
   output logic              deb_long
);
   localparam int HALF = CLK_HZ / (2 * FLASH_HZ);

   generate
      if (FLASH_HZ < 1 || CLK_HZ < 2 * FLASH_HZ) begin : g_bad_rate
         $error("led_stop_ctrl: CLK_HZ must be at least twice FLASH_HZ");
      end
   endgenerate

   logic [STOP_W-1:0] stop_lvl;
   lsc_mode_t         mode;
   logic              play_q, sect_q, phase, restart, led2;

   assign restart = playing & ~play_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         play_q <= 1'b0;
         sect_q <= 1'b0;
      end else begin
         play_q <= playing;
         sect_q <= sect_led_on;
      end
   end

   lsc_regs #(.DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(lsc_sel_e'(reg_sel)),
      .wdata(reg_wdata), .stop_lvl(stop_lvl), .mode(mode));

   lsc_flash_div #(.HALF(HALF)) i_div (
      .clk(clk), .rst_n(rst_n), .restart(restart), .phase(phase));

   lsc_led_drive i_led (
      .play_q(play_q), .sect_q(sect_q), .phase(phase), .flash(mode.flash),
      .lvl_c(stop_lvl[2]), .opt_alternate(opt_alternate),
      .opt_led1_sect(opt_led1_sect), .opt_led2_sect(opt_led2_sect),
      .led1(led1), .led2(led2));

   lsc_pin_mux i_pin (
      .mode(mode), .led2(led2), .lvl_c(stop_lvl[2]),
      .pin_out(pin4_out), .pin_oe(pin4_oe));

   assign stpa     = stop_lvl[0];
   assign stpb     = stop_lvl[1];
   assign deb_long = mode.deb_long;

   // R2
   stop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel) |=> (stpa == $past(reg_wdata[0]) && stpb == $past(reg_wdata[1])));
   // R4
   trig_pin_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode.pin_trig |-> (!pin4_oe && !pin4_out));
   // R7
   idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !play_q |-> !led1);
   // R10
   led2_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!opt_led2_sect && !mode.pin_trig) |-> (pin4_out == stop_lvl[2]));
endmodule

// File: tb/test_led_stop_ctrl.sv
`timescale 1ns/1ps
module test_led_stop_ctrl;
   localparam int CLK_HZ = 60, FLASH_HZ = 3;
   localparam int HALF   = CLK_HZ / (2 * FLASH_HZ);

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 0, reg_sel = 0;
   logic [7:0] reg_wdata = 0;
   logic playing = 0, sect_led_on = 0;
   logic opt_alternate = 0, opt_led1_sect = 1, opt_led2_sect = 1;
   logic led1, pin4_out, pin4_oe, stpa, stpb, deb_long;

   int tests = 0, fails = 0;

   // model state
   logic [2:0] m_stop = 3'b111;
   logic [3:0] m_mode = 4'b1111;   // flash, pin_led2, pin_trig, deb_long
   logic m_play = 0, m_sect = 0;
   int   m_n = 0;

   always #2.5 clk = ~clk;

   led_stop_ctrl #(.CLK_HZ(CLK_HZ), .FLASH_HZ(FLASH_HZ)) i_led_stop_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .playing(playing), .sect_led_on(sect_led_on), .opt_alternate(opt_alternate),
      .opt_led1_sect(opt_led1_sect), .opt_led2_sect(opt_led2_sect),
      .led1(led1), .pin4_out(pin4_out), .pin4_oe(pin4_oe),
      .stpa(stpa), .stpb(stpb), .deb_long(deb_long));

   function automatic logic exp_wave(input logic second);
      logic ph;
      ph = ((m_n / HALF) % 2) != 0;
      if (!m_mode[3]) return 1'b1;
      return (second && opt_alternate) ? ph : ~ph;
   endfunction

   function automatic logic exp_led1();
      logic en;
      en = opt_led1_sect ? (m_play & m_sect) : m_play;
      return en & exp_wave(1'b0);
   endfunction

   function automatic logic exp_led2();
      if (!opt_led2_sect) return m_stop[2];
      return m_play & m_sect & exp_wave(1'b1);
   endfunction

   task automatic cmp(input string tag, input string what, input logic got, input logic exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s got %b expected %b (n=%0d)", tag, what, got, exp, m_n);
      end
   endtask

   task automatic check_all(input string tag);
      cmp(tag, "stpa", stpa, m_stop[0]);
      cmp(tag, "stpb", stpb, m_stop[1]);
      cmp(tag, "deb_long", deb_long, m_mode[0]);
      cmp(tag, "pin4_oe", pin4_oe, ~m_mode[1]);
      cmp(tag, "pin4_out", pin4_out, m_mode[1] ? 1'b0 : (m_mode[2] ? exp_led2() : m_stop[2]));
      cmp(tag, "led1", led1, exp_led1());
   endtask

   // one clock edge; the model follows the inputs applied before it
   task automatic step(input string tag);
      @(posedge clk);
      if (reg_wr) begin
         if (reg_sel) m_mode = reg_wdata[7:4];
         else         m_stop = reg_wdata[2:0];
      end
      if (playing && !m_play) m_n = 0; else m_n++;
      m_play = playing;
      m_sect = sect_led_on;
      #1;
      reg_wr = 0;
      check_all(tag);
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] d, input string tag);
      reg_wr = 1; reg_sel = sel; reg_wdata = d;
      step(tag);
   endtask

   task automatic run(input int cycles, input string tag);
      for (int i = 0; i < cycles; i++) step(tag);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 reset");
      cmp("R1", "pin4_oe", pin4_oe, 1'b0);
      rst_n = 1;
      step("R1 after release");

      // stop register, high bits ignored
      wr_reg(0, 8'hF8, "R2 write F8");
      wr_reg(0, 8'h43, "R2 write 43");
      cmp("R2", "stpa", stpa, 1'b1);
      // mode register, low bits ignored: pin output carrying C level
      wr_reg(1, 8'h0F, "R3 write 0F");
      cmp("R3", "deb_long", deb_long, 1'b0);
      cmp("R4", "pin4_out C level", pin4_out, 1'b0);
      wr_reg(0, 8'h04, "R4 C high");
      cmp("R4", "pin4_out C level", pin4_out, 1'b1);

      // in-phase flash on LED1 and LED2 on pin
      wr_reg(1, 8'hC0, "R4 led2 on pin");
      sect_led_on = 1; playing = 1;
      run(4 * HALF + 3, "R5 flash");
      // restart mid-wave
      playing = 0; run(3, "R7 stopped");
      playing = 1; step("R11 restart");
      cmp("R11", "led1 on after restart", led1, 1'b1);
      run(2 * HALF, "R11 wave");

      opt_alternate = 1;
      run(3 * HALF, "R8 alternate");
      wr_reg(1, 8'h40, "R6 steady");
      run(HALF + 5, "R6 steady");

      // section gating
      wr_reg(1, 8'hC0, "R7 flash");
      for (int i = 0; i < 30; i++) begin
         sect_led_on = (i % 7) < 3;
         step("R7 gate");
      end
      opt_led1_sect = 0; sect_led_on = 0;
      run(2 * HALF, "R9 led1 no section");
      opt_led1_sect = 1; opt_led2_sect = 0;
      wr_reg(0, 8'h00, "R10 C low");
      wr_reg(0, 8'h04, "R10 C high");
      run(3, "R10 level");
      opt_led2_sect = 1;

      // mode write on the same edge as playback start
      playing = 0; run(2, "R11 idle");
      playing = 1; sect_led_on = 1;
      reg_wr = 1; reg_sel = 1; reg_wdata = 8'h80;
      step("R11 R3 collide");
      cmp("R11", "led1 on at start", led1, 1'b1);
      run(HALF + 2, "R5 after collide");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 8) == 0) begin
            reg_wr = 1; reg_sel = $urandom % 2; reg_wdata = 8'($urandom);
         end
         if (($urandom % 25) == 0) playing = ~playing;
         if (($urandom % 10) == 0) sect_led_on = $urandom % 2;
         if (($urandom % 200) == 0) begin
            opt_alternate = $urandom % 2;
            opt_led1_sect = $urandom % 2;
            opt_led2_sect = $urandom % 2;
         end
         step("RND R2 R3 R4 R5 R7 R8");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule